// File: doc/BRIEF.md
# Configurable I/O Cell

The cell sits between a chip pad and the core logic. It has three separate paths. The output path carries `core_o` to the pad driver. The enable path carries `core_oe` to the driver's three-state control. The input path carries the resolved pad level back to `core_i`. Each path either passes its signal straight through or routes it through its own storage element. Each storage element can be set up as an edge-triggered flip-flop or as a level-sensitive latch. It has its own clock enable and its own set/reset. The set/reset value is configurable, and so is its timing (at the clock edge or immediate). The input path also has a selectable delay of 0 to 3 clock cycles, placed before its storage element or bypass.

The pad is modelled as a driver value (`pad_o`) and a driver enable (`pad_oe`). An external agent may also drive the pad through `pad_ext_drive`/`pad_ext_val`. The resolved level appears on `pad_lvl`. When nothing drives the pad, it resolves to a configured pull-up, a pull-down, or a keeper that holds the last driven level.

Configuration is a single word, written through `cfg_we`/`cfg_wdata` while the cell is held in reset. A two-state controller sequences the cell:
- ST_HOLD is entered asynchronously whenever `rst_n` is low. In this state the configuration is writable and the driver is off.
- The transition HOLD→RUN is taken on the first rising edge after `rst_n` rises. This edge only arms the cell and captures no data.
- ST_RUN has no exit except a new reset. In this state the configuration is frozen.

Top module: `iocell`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_o` are both 0, whatever the configuration and core inputs.
- R2: A configuration word is taken at a rising edge where `cfg_we` is 1 and the cell is in ST_HOLD. In ST_RUN, writes are ignored. The bit fields are:
  - [3:0] input element
  - [7:4] output element
  - [11:8] enable element
  - [13:12] input delay
  - [15:14] pad resolution

  Each element field holds, from bit 0 upward: registered (1 = through storage), latch (1 = latch, 0 = flip-flop), set/reset value, and set/reset immediate (1 = immediate, 0 = at the edge).
- R3: A path whose registered bit is 0 passes its input to its output in the same cycle, and its CE and SR have no effect.
- R4: In flip-flop mode the element captures its input at a rising edge where CE is 1 and holds it otherwise. The arming edge (HOLD→RUN) captures nothing, so the element still shows its reset value 0.
- R5: In latch mode the element output follows its input while CE is 1. It holds the value present at the last edge with CE high once CE is 0.
- R6: With edge-timed set/reset, SR at a rising edge loads the set/reset value, taking priority over CE. The output does not change before that edge.
- R7: With immediate set/reset, SR forces the element output to the set/reset value in the same cycle. The value stays after SR is removed.
- R8: `pad_oe` is the enable path output and `pad_o` is the output path output. When `pad_oe` is 1, `pad_lvl` equals `pad_o`.
- R9: When `pad_oe` is 0 and `pad_ext_drive` is 1, `pad_lvl` equals `pad_ext_val`.
- R10: When the pad is undriven, the resolution code sets `pad_lvl`:
  - 01 gives 0.
  - 10 gives 1.
  - 00 or 11 gives the level the pad had at the most recent edge where it was driven.
- R11: With input delay d (0 to 3), the input path sees `pad_lvl` delayed by d rising edges, counted from the edge after arming. Earlier stages hold 0.
- R12: `core_i` is the input path output. In flip-flop mode with CE high, this adds one edge of lag after the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; holds the cell in ST_HOLD |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| core_o | input | 1 | Core data towards the pad |
| core_oe | input | 1 | Core driver enable request |
| ce_in | input | 1 | Clock enable, input element |
| ce_out | input | 1 | Clock enable, output element |
| ce_oe | input | 1 | Clock enable, enable element |
| sr_in | input | 1 | Set/reset, input element |
| sr_out | input | 1 | Set/reset, output element |
| sr_oe | input | 1 | Set/reset, enable element |
| pad_ext_drive | input | 1 | External agent drives the pad |
| pad_ext_val | input | 1 | Level driven by the external agent |
| core_i | output | 1 | Input path result to the core |
| pad_o | output | 1 | Pad driver value |
| pad_oe | output | 1 | Pad driver enable |
| pad_lvl | output | 1 | Resolved pad level |

## Verification
The assertions check the following on every cycle:
- the driver stays off during reset;
- the configuration stays frozen in ST_RUN;
- a bypassed output path stays transparent;
- an idle flip-flop holds its value;
- the resolved level agrees with the driver, the external agent and the pull codes.

Other behaviours need whole sequences, and only the bench scenarios show them:
- latch transparency and hold;
- the difference between edge-timed and immediate set/reset;
- the capture-free arming edge;
- the keeper remembering a level across an undriven stretch;
- the exact lag of each input delay setting, with and without the input flip-flop.

// File: rtl/iocell_pkg.sv
`timescale 1ns/1ps
package iocell_pkg;

    localparam int ELEM_W  = 4;
    localparam int NPATH   = 3;
    localparam int RES_W   = 2;
    localparam int P_IN    = 0;
    localparam int P_OUT   = 1;
    localparam int P_OE    = 2;

    // one storage element's setup, bit 0 = registered
    typedef struct packed {
        logic sr_now;      // 1: set/reset acts at once, 0: at the edge
        logic sr_val;      // value loaded by set/reset
        logic latch;       // 1: level-sensitive, 0: edge-triggered
        logic registered;  // 1: through storage, 0: bypass
    } elem_cfg_t;

    typedef enum logic [RES_W-1:0] {
        RES_KEEP_A = 2'b00,
        RES_LOW    = 2'b01,
        RES_HIGH   = 2'b10,
        RES_KEEP_B = 2'b11
    } pad_res_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } cell_state_e;

endpackage

// File: rtl/iocell_ctrl.sv
`timescale 1ns/1ps
module iocell_ctrl
    import iocell_pkg::*;
#(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             run,
    output logic [CFG_W-1:0] cfg_q
);

    cell_state_e state_q;
    cell_state_e state_d;
    logic        cfg_open;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = ST_RUN;   // arming edge
            ST_RUN:  state_d = ST_RUN;   // left only through reset
        endcase
    end

    // state outputs
    always_comb begin
        run      = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_HOLD: cfg_open = 1'b1;
            ST_RUN:  run      = 1'b1;
        endcase
    end

    // configuration word, writable only while held
    always_ff @(posedge clk) begin
        if (cfg_we && cfg_open) begin
            cfg_q <= cfg_wdata;
        end
    end

endmodule

// File: rtl/iocell_store.sv
`timescale 1ns/1ps
module iocell_store
    import iocell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  elem_cfg_t cfg,
    input  logic      d,
    input  logic      ce,
    input  logic      sr,
    output logic      y
);

    logic q_r;
    logic act_ce;
    logic act_sr;

    assign act_ce = run & ce;
    assign act_sr = run & sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= 1'b0;
        end else if (act_sr) begin
            q_r <= cfg.sr_val;
        end else if (act_ce) begin
            q_r <= d;
        end
    end

    always_comb begin
        if (!cfg.registered) begin
            y = d;
        end else if (act_sr && cfg.sr_now) begin
            y = cfg.sr_val;
        end else if (cfg.latch && act_ce) begin
            y = d;
        end else begin
            y = q_r;
        end
    end

endmodule

// File: rtl/iocell_dly.sv
`timescale 1ns/1ps
module iocell_dly #(
    parameter int DEPTH = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             d,
    output logic             y
);

    logic [DEPTH-1:0] sh;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= '0;
                end else if (run) begin
                    sh <= d;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh <= '0;
                end else if (run) begin
                    sh <= {sh[DEPTH-2:0], d};
                end
            end
        end
    endgenerate

    always_comb begin
        y = d;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(sel) == k) begin
                y = sh[k-1];
            end
        end
        if (int'(sel) > DEPTH) begin
            y = sh[DEPTH-1];
        end
    end

endmodule

// File: rtl/iocell_pad.sv
`timescale 1ns/1ps
module iocell_pad
    import iocell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  pad_res_e res,
    input  logic     drv_o,
    input  logic     drv_oe,
    input  logic     ext_drive,
    input  logic     ext_val,
    output logic     lvl
);

    logic keep_q;
    logic driven;

    assign driven = drv_oe | ext_drive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_q <= 1'b0;
        end else if (run && driven) begin
            keep_q <= lvl;
        end
    end

    always_comb begin
        if (drv_oe) begin
            lvl = drv_o;
        end else if (ext_drive) begin
            lvl = ext_val;
        end else begin
            unique case (res)
                RES_LOW:    lvl = 1'b0;
                RES_HIGH:   lvl = 1'b1;
                RES_KEEP_A: lvl = keep_q;
                RES_KEEP_B: lvl = keep_q;
            endcase
        end
    end

endmodule

// File: rtl/iocell.sv
`timescale 1ns/1ps
module iocell
    import iocell_pkg::*;
#(
    parameter int DLY_MAX = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [15:0] cfg_wdata,
    input  logic        core_o,
    input  logic        core_oe,
    input  logic        ce_in,
    input  logic        ce_out,
    input  logic        ce_oe,
    input  logic        sr_in,
    input  logic        sr_out,
    input  logic        sr_oe,
    input  logic        pad_ext_drive,
    input  logic        pad_ext_val,
    output logic        core_i,
    output logic        pad_o,
    output logic        pad_oe,
    output logic        pad_lvl
);

    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int DLY_LSB = NPATH * ELEM_W;
    localparam int RES_LSB = DLY_LSB + DLY_W;
    localparam int CFG_W   = RES_LSB + RES_W;

    logic             run;
    logic [CFG_W-1:0] cfg_q;
    logic [NPATH-1:0] path_d;
    logic [NPATH-1:0] path_ce;
    logic [NPATH-1:0] path_sr;
    logic [NPATH-1:0] path_y;
    logic             dly_y;
    logic [DLY_W-1:0] dly_sel;
    pad_res_e         res_sel;

    iocell_ctrl #(.CFG_W(CFG_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata[CFG_W-1:0]),
        .run       (run),
        .cfg_q     (cfg_q)
    );

    assign dly_sel = cfg_q[DLY_LSB +: DLY_W];
    assign res_sel = pad_res_e'(cfg_q[RES_LSB +: RES_W]);

    iocell_dly #(.DEPTH(DLY_MAX), .SEL_W(DLY_W)) i_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (dly_sel),
        .d     (pad_lvl),
        .y     (dly_y)
    );

    assign path_d[P_IN]   = dly_y;
    assign path_d[P_OUT]  = core_o;
    assign path_d[P_OE]   = core_oe;
    assign path_ce[P_IN]  = ce_in;
    assign path_ce[P_OUT] = ce_out;
    assign path_ce[P_OE]  = ce_oe;
    assign path_sr[P_IN]  = sr_in;
    assign path_sr[P_OUT] = sr_out;
    assign path_sr[P_OE]  = sr_oe;

    generate
        for (genvar p = 0; p < NPATH; p++) begin : g_path
            iocell_store i_store (
                .clk   (clk),
                .rst_n (rst_n),
                .run   (run),
                .cfg   (elem_cfg_t'(cfg_q[p*ELEM_W +: ELEM_W])),
                .d     (path_d[p]),
                .ce    (path_ce[p]),
                .sr    (path_sr[p]),
                .y     (path_y[p])
            );
        end
    endgenerate

    // driver stays off until the cell runs
    assign pad_o   = run & path_y[P_OUT];
    assign pad_oe  = run & path_y[P_OE];
    assign core_i  = path_y[P_IN];

    iocell_pad i_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .res       (res_sel),
        .drv_o     (pad_o),
        .drv_oe    (pad_oe),
        .ext_drive (pad_ext_drive),
        .ext_val   (pad_ext_val),
        .lvl       (pad_lvl)
    );

endmodule

// File: rtl/iocell_chk.sv
`timescale 1ns/1ps
module iocell_chk #(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CFG_W-1:0] cfg_q,
    input logic             core_o,
    input logic             ce_out,
    input logic             sr_out,
    input logic             pad_o,
    input logic             pad_oe,
    input logic             pad_lvl,
    input logic             pad_ext_drive,
    input logic             pad_ext_val
);

    logic       out_reg;
    logic       out_latch;
    logic [1:0] res;

    assign out_reg   = cfg_q[4];
    assign out_latch = cfg_q[5];
    assign res       = cfg_q[CFG_W-1 -: 2];

    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            AST_HOLD_DRIVER_OFF: assert (!pad_oe && !pad_o); // R1
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(cfg_q)); // R2

    AST_OUT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !out_reg) |-> (pad_o == core_o)); // R3

    AST_FF_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && out_reg && !out_latch && !ce_out && !sr_out)
        |=> (sr_out || $stable(pad_o))); // R4

    AST_DRIVEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (pad_lvl == pad_o)); // R8

    AST_EXT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_oe && pad_ext_drive) |-> (pad_lvl == pad_ext_val)); // R9

    AST_PULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pad_oe && !pad_ext_drive && res == 2'b10) |-> pad_lvl); // R10

    AST_PULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pad_oe && !pad_ext_drive && res == 2'b01) |-> !pad_lvl); // R10

endmodule

bind iocell iocell_chk #(.CFG_W(CFG_W)) i_iocell_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .cfg_q         (cfg_q),
    .core_o        (core_o),
    .ce_out        (ce_out),
    .sr_out        (sr_out),
    .pad_o         (pad_o),
    .pad_oe        (pad_oe),
    .pad_lvl       (pad_lvl),
    .pad_ext_drive (pad_ext_drive),
    .pad_ext_val   (pad_ext_val)
);

// File: tb/test_iocell.sv
`timescale 1ns/1ps
module test_iocell;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        core_o = 1'b0, core_oe = 1'b0;
    logic        ce_in = 1'b0, ce_out = 1'b0, ce_oe = 1'b0;
    logic        sr_in = 1'b0, sr_out = 1'b0, sr_oe = 1'b0;
    logic        pad_ext_drive = 1'b0, pad_ext_val = 1'b0;
    logic        core_i, pad_o, pad_oe, pad_lvl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam int S_PO = 0, S_POE = 1, S_LVL = 2, S_CI = 3;

    typedef struct {
        int   req;
        int   sig;
        logic val;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    iocell i_iocell (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .core_o(core_o), .core_oe(core_oe),
        .ce_in(ce_in), .ce_out(ce_out), .ce_oe(ce_oe),
        .sr_in(sr_in), .sr_out(sr_out), .sr_oe(sr_oe),
        .pad_ext_drive(pad_ext_drive), .pad_ext_val(pad_ext_val),
        .core_i(core_i), .pad_o(pad_o), .pad_oe(pad_oe), .pad_lvl(pad_lvl)
    );

    function automatic logic pick(input int s);
        case (s)
            S_PO:    return pad_o;
            S_POE:   return pad_oe;
            S_LVL:   return pad_lvl;
            default: return core_i;
        endcase
    endfunction

    function automatic string sname(input int s);
        case (s)
            S_PO:    return "pad_o";
            S_POE:   return "pad_oe";
            S_LVL:   return "pad_lvl";
            default: return "core_i";
        endcase
    endfunction

    // element field: {sr_now, sr_val, latch, registered}
    function automatic logic [3:0] elem(input logic rg, input logic lt,
                                        input logic sv, input logic sn);
        return {sn, sv, lt, rg};
    endfunction

    function automatic logic [15:0] mk(input logic [3:0] ein, input logic [3:0] eout,
                                       input logic [3:0] eoe, input logic [1:0] dly,
                                       input logic [1:0] res);
        return {res, dly, eoe, eout, ein};
    endfunction

    task automatic expect_sig(input int req, input int sig, input logic val);
        item_t it;
        it.req = req;
        it.sig = sig;
        it.val = val;
        sb.push_back(it);
    endtask

    // driver step: just after the falling edge
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // monitor: compares queued items before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic  act;
                it  = sb.pop_front();
                act = pick(it.sig);
                n_checks++;
                if (act !== it.val) begin
                    n_fail++;
                    $display("FAIL R%0d %s actual=%b expected=%b at %0t",
                             it.req, sname(it.sig), act, it.val, $time);
                end
            end
        end
    end

    task automatic load_cfg(input logic [15:0] w);
        tick();
        rst_n = 1'b0;
        cfg_we = 1'b1;
        cfg_wdata = w;
        core_o = 1'b1; core_oe = 1'b1;
        ce_in = 1'b1; ce_out = 1'b1; ce_oe = 1'b1;
        sr_in = 1'b0; sr_out = 1'b0; sr_oe = 1'b0;
        pad_ext_drive = 1'b0; pad_ext_val = 1'b0;
        tick();
        cfg_we = 1'b0;
        expect_sig(1, S_POE, 1'b0); // R1
        expect_sig(1, S_PO, 1'b0);  // R1
        tick();
        rst_n = 1'b1;               // arming edge follows
    endtask

    localparam logic [3:0] E_BYP = 4'b0000;
    localparam logic [9:0] PAT   = 10'b1101001101;

    task automatic delay_run(input logic [3:0] ein, input logic [1:0] dly,
                             input int lag, input int req);
        logic hist [0:15];
        load_cfg(mk(ein, E_BYP, E_BYP, dly, 2'b10));
        for (int k = 1; k <= 12; k++) begin
            tick();
            core_o = PAT[k % 10];
            hist[k] = core_o;
            expect_sig(req, S_CI, (k - lag >= 1) ? hist[k-lag] : 1'b0); // R11 R12
        end
    endtask

    initial begin
        // scenario: every path bypassed, pull-up
        load_cfg(mk(E_BYP, E_BYP, E_BYP, 2'd0, 2'b10));
        tick(); core_o = 1'b1; core_oe = 1'b1;
        expect_sig(3, S_PO, 1'b1);   // R3
        expect_sig(8, S_POE, 1'b1);  // R8
        expect_sig(8, S_LVL, 1'b1);  // R8
        expect_sig(12, S_CI, 1'b1);  // R12
        tick(); core_o = 1'b0;
        expect_sig(3, S_PO, 1'b0);   // R3
        expect_sig(8, S_LVL, 1'b0);  // R8
        expect_sig(3, S_CI, 1'b0);   // R3
        tick(); core_oe = 1'b0;
        expect_sig(10, S_LVL, 1'b1); // R10 pull-up
        expect_sig(3, S_CI, 1'b1);   // R3
        tick(); pad_ext_drive = 1'b1; pad_ext_val = 1'b0;
        expect_sig(9, S_LVL, 1'b0);  // R9
        tick(); pad_ext_drive = 1'b0;
        cfg_we = 1'b1; cfg_wdata = mk(E_BYP, E_BYP, E_BYP, 2'd0, 2'b01);
        expect_sig(10, S_LVL, 1'b1); // R10
        tick(); cfg_we = 1'b0;
        expect_sig(2, S_LVL, 1'b1);  // R2 write while running ignored

        // scenario: output flip-flop, edge-timed set/reset to 0, pull-down
        load_cfg(mk(E_BYP, elem(1'b1, 1'b0, 1'b0, 1'b0), E_BYP, 2'd0, 2'b01));
        tick(); core_o = 1'b1; ce_out = 1'b1;
        expect_sig(4, S_PO, 1'b0);   // R4 arming edge captured nothing
        tick(); core_o = 1'b0; ce_out = 1'b0;
        expect_sig(4, S_PO, 1'b1);   // R4 captured
        tick(); sr_out = 1'b1; ce_out = 1'b1; core_o = 1'b1;
        expect_sig(4, S_PO, 1'b1);   // R4 held with CE low
        expect_sig(6, S_PO, 1'b1);   // R6 no change before the edge
        tick(); sr_out = 1'b0; ce_out = 1'b0;
        expect_sig(6, S_PO, 1'b0);   // R6 SR beat CE
        tick(); core_oe = 1'b0;
        expect_sig(10, S_LVL, 1'b0); // R10 pull-down

        // scenario: output latch, immediate set/reset to 1, keeper
        load_cfg(mk(E_BYP, elem(1'b1, 1'b1, 1'b1, 1'b1), E_BYP, 2'd0, 2'b00));
        tick(); ce_out = 1'b1; core_o = 1'b1;
        expect_sig(5, S_PO, 1'b1);   // R5 transparent
        tick(); ce_out = 1'b0; core_o = 1'b0;
        expect_sig(5, S_PO, 1'b1);   // R5 holds
        tick(); ce_out = 1'b1; core_o = 1'b0;
        expect_sig(5, S_PO, 1'b0);   // R5 transparent
        tick(); ce_out = 1'b0; core_o = 1'b1;
        expect_sig(5, S_PO, 1'b0);   // R5 holds
        tick(); sr_out = 1'b1;
        expect_sig(7, S_PO, 1'b1);   // R7 immediate
        tick(); sr_out = 1'b0;
        expect_sig(7, S_PO, 1'b1);   // R7 persists
        tick(); core_oe = 1'b0;
        expect_sig(10, S_LVL, 1'b1); // R10 keeper holds 1
        tick(); pad_ext_drive = 1'b1; pad_ext_val = 1'b0;
        expect_sig(9, S_LVL, 1'b0);  // R9
        tick(); pad_ext_drive = 1'b0;
        expect_sig(10, S_LVL, 1'b0); // R10 keeper holds 0

        // scenario: enable path flip-flop
        load_cfg(mk(E_BYP, E_BYP, elem(1'b1, 1'b0, 1'b0, 1'b0), 2'd0, 2'b01));
        tick(); core_oe = 1'b1; ce_oe = 1'b1; core_o = 1'b1;
        expect_sig(8, S_POE, 1'b0);  // R8
        expect_sig(10, S_LVL, 1'b0); // R10
        tick(); core_oe = 1'b0;
        expect_sig(8, S_POE, 1'b1);  // R8
        expect_sig(8, S_LVL, 1'b1);  // R8
        tick();
        expect_sig(8, S_POE, 1'b0);  // R8

        // scenario: input delays
        delay_run(E_BYP, 2'd2, 2, 11);                          // R11
        delay_run(elem(1'b1, 1'b0, 1'b0, 1'b0), 2'd3, 4, 12);   // R12
        delay_run(E_BYP, 2'd1, 1, 11);                          // R11

        tick();
        tick();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule